// File: doc/BRIEF.md
# Shared Internal Signal Bank with Claimable Bits

This block is a 32-bit bank of internal signal lines that eight cores share. None of the lines leaves the chip. A second 32-bit map sits alongside the bank and records which bits are taken. A core takes bits by presenting a mask, in the way it would take a lock. It can drive only the bits it holds. When it has finished with them, it gives them back.

Every core sees the current bank value and the ownership map. A core can also park on a pattern. It supplies a mask and a target, and it stalls until the masked bank value equals the masked target. The block compares the two on every clock. Cores can use this to hand data to each other and to synchronise without a round trip through shared memory.

Top module: `shared_pin_bank`

## Requirements
- R1: After reset, `own_map`, `bank_value`, `claim_ok`, `claim_grant`, `wait_stall` and `wait_done` are all zero.
- R2: A claim is answered one cycle after the request. If no bit of the mask is held by another core, `claim_ok` for that core is 1, its `claim_grant` slice equals the mask, and the bits join `own_map`. If any bit is held by another core, the whole claim is refused: `claim_ok` is 0, the grant slice is 0, and `own_map` is unchanged.
- R3: When claims arrive in the same cycle, the lower-numbered core takes priority. A higher-numbered core's claim that overlaps a bit granted to a lower core in that cycle is refused as a whole. Claims that do not overlap each other are all granted.
- R4: `bank_value` is the bitwise OR of each core's output bits, each masked by the bits that core holds. A bit that nobody holds reads 0.
- R5: A write sets the core's output bits to `wr_data` only where the core holds the bit after that cycle's claim and release. Bits it does not hold are ignored, and a bit that has just been claimed reads 0 until its owner writes it.
- R6: A release clears the core's ownership of the masked bits and removes its drive from them on the next cycle.
- R7: `own_map` is the union of the bits held by all cores, so any core can see which bits are free.
- R8: A wait request latches the core's mask and target and raises `wait_stall` from the next cycle. The first cycle in which `(bank_value & mask) == (target & mask)` holds is the match cycle. On the cycle after it, `wait_stall` drops and `wait_done` pulses high for exactly one cycle.
- R9: If the pattern already matches when the wait starts, `wait_done` pulses two cycles after the request cycle.
- R10: A core may claim bits it already holds. Such a claim succeeds and leaves its output values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| claim_req | input | NC | Claim request, one bit per core |
| claim_mask | input | NC*W | Bits each core wants to take (core c in slice c*W) |
| rel_req | input | NC | Release request, one bit per core |
| rel_mask | input | NC*W | Bits each core gives back |
| wr_req | input | NC | Write request, one bit per core |
| wr_data | input | NC*W | New output bits per core |
| wait_req | input | NC | Start a pattern wait, one bit per core |
| wait_mask | input | NC*W | Bits that take part in the compare |
| wait_target | input | NC*W | Value the masked bank must equal |
| claim_ok | output | NC | One-cycle pulse: the claim was granted |
| claim_grant | output | NC*W | Bits granted by the claim (zero if refused) |
| wait_stall | output | NC | The core is waiting for its pattern |
| wait_done | output | NC | One-cycle pulse when the wait ends |
| bank_value | output | W | Current bank value |
| own_map | output | W | Union of the bits held by all cores |

## Verification
The checks assume that a core does not start a new wait while `wait_stall` is high, and that reset is held for at least one clock edge. The bench starts each wait only after the previous one has completed. It applies claims, writes and releases one at a time through the vector table. Simultaneous claims from several cores are applied only in the directed priority test.

// File: rtl/shared_pin_bank.sv
module shared_pin_bank #(
  parameter int NC = 8,
  parameter int W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NC-1:0]   claim_req,
  input  logic [NC*W-1:0] claim_mask,
  input  logic [NC-1:0]   rel_req,
  input  logic [NC*W-1:0] rel_mask,
  input  logic [NC-1:0]   wr_req,
  input  logic [NC*W-1:0] wr_data,
  input  logic [NC-1:0]   wait_req,
  input  logic [NC*W-1:0] wait_mask,
  input  logic [NC*W-1:0] wait_target,
  output logic [NC-1:0]   claim_ok,
  output logic [NC*W-1:0] claim_grant,
  output logic [NC-1:0]   wait_stall,
  output logic [NC-1:0]   wait_done,
  output logic [W-1:0]    bank_value,
  output logic [W-1:0]    own_map
);

  logic [W-1:0] own_q  [NC];
  logic [W-1:0] out_q  [NC];
  logic [W-1:0] wm_q   [NC];
  logic [W-1:0] wt_q   [NC];
  logic [W-1:0] gnt_q  [NC];
  logic [W-1:0] gnt_c  [NC];
  logic [W-1:0] own_n  [NC];
  logic [NC-1:0] ok_c, ok_q, waiting_q, done_q, match_c;
  logic [W-1:0] all_own, bank;

  always_comb begin
    all_own = '0;
    bank    = '0;
    for (int c = 0; c < NC; c++) begin
      all_own = all_own | own_q[c];
      bank    = bank | (out_q[c] & own_q[c]);
    end
  end

  always_comb begin
    logic [W-1:0] taken;
    taken = '0;
    for (int c = 0; c < NC; c++) begin
      logic [W-1:0] m;
      m = claim_mask[c*W +: W];
      ok_c[c]  = claim_req[c] && ((m & ((all_own & ~own_q[c]) | taken)) == '0);
      gnt_c[c] = ok_c[c] ? m : '0;
      taken    = taken | gnt_c[c];
      own_n[c] = (own_q[c] & ~(rel_req[c] ? rel_mask[c*W +: W] : '0)) | gnt_c[c];
      match_c[c] = waiting_q[c] && ((bank & wm_q[c]) == (wt_q[c] & wm_q[c]));
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (!rst_n) begin
        own_q[c] <= '0;
        out_q[c] <= '0;
        wm_q[c]  <= '0;
        wt_q[c]  <= '0;
        gnt_q[c] <= '0;
        ok_q[c]  <= 1'b0;
        waiting_q[c] <= 1'b0;
        done_q[c]    <= 1'b0;
      end else begin
        own_q[c] <= own_n[c];
        out_q[c] <= (wr_req[c] ? wr_data[c*W +: W] : out_q[c]) & own_n[c];
        gnt_q[c] <= gnt_c[c];
        ok_q[c]  <= ok_c[c];
        done_q[c] <= match_c[c];
        if (wait_req[c]) begin
          wm_q[c] <= wait_mask[c*W +: W];
          wt_q[c] <= wait_target[c*W +: W];
          waiting_q[c] <= 1'b1;
        end else if (match_c[c]) begin
          waiting_q[c] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_out
    assign claim_grant[g*W +: W] = gnt_q[g];
  end

  assign claim_ok   = ok_q;
  assign wait_stall = waiting_q;
  assign wait_done  = done_q;
  assign bank_value = bank;
  assign own_map    = all_own;

endmodule

module shared_pin_bank_chk #(
  parameter int NC = 8,
  parameter int W  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NC-1:0]   claim_req,
  input logic [NC-1:0]   claim_ok,
  input logic [NC*W-1:0] claim_grant,
  input logic [NC-1:0]   wait_stall,
  input logic [NC-1:0]   wait_done,
  input logic [W-1:0]    bank_value,
  input logic [W-1:0]    own_map
);

  p_bank_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_value & ~own_map) == '0);

  for (genvar g = 0; g < NC; g++) begin : g_core
    p_refused_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_ok[g] |-> claim_grant[g*W +: W] == '0);
    p_grant_in_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      claim_ok[g] |-> (claim_grant[g*W +: W] & ~own_map) == '0);
    p_ok_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      claim_ok[g] |-> $past(claim_req[g]));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wait_done[g] |=> !wait_done[g]);
    p_done_unstalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wait_done[g] |-> !wait_stall[g]);
  end

endmodule

bind shared_pin_bank shared_pin_bank_chk #(.NC(NC), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .claim_ok(claim_ok),
  .claim_grant(claim_grant), .wait_stall(wait_stall), .wait_done(wait_done),
  .bank_value(bank_value), .own_map(own_map)
);

// File: tb/shared_pin_bank_bench.sv
`timescale 1ns/1ps
module shared_pin_bank_bench;
  localparam int NC = 8;
  localparam int W  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]   claim_req, rel_req, wr_req, wait_req;
  logic [NC*W-1:0] claim_mask, rel_mask, wr_data, wait_mask, wait_target;
  logic [NC-1:0]   claim_ok, wait_stall, wait_done;
  logic [NC*W-1:0] claim_grant;
  logic [W-1:0]    bank_value, own_map;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shared_pin_bank #(.NC(NC), .W(W)) u_shared_pin_bank (.*);

  // {op[1:0], core[2:0], mask[31:0], data[31:0], exp_ok, exp_map[31:0], exp_bank[31:0]}
  // op: 0 claim, 1 release, 2 write
  localparam int NV = 12;
  localparam logic [133:0] VEC [NV] = '{
    {2'd0, 3'd0, 32'h0000_00FF, 32'h0, 1'b1, 32'h0000_00FF, 32'h0000_0000}, // R2
    {2'd2, 3'd0, 32'h0, 32'hFFFF_FFFF, 1'b0, 32'h0000_00FF, 32'h0000_00FF}, // R5
    {2'd0, 3'd1, 32'h0000_0F00, 32'h0, 1'b1, 32'h0000_0FFF, 32'h0000_00FF}, // R7
    {2'd0, 3'd2, 32'h0000_1100, 32'h0, 1'b0, 32'h0000_0FFF, 32'h0000_00FF}, // R2 refused
    {2'd2, 3'd2, 32'h0, 32'hFFFF_FFFF, 1'b0, 32'h0000_0FFF, 32'h0000_00FF}, // R5 ignored
    {2'd0, 3'd2, 32'h0000_F000, 32'h0, 1'b1, 32'h0000_FFFF, 32'h0000_00FF}, // R5 new bits 0
    {2'd2, 3'd1, 32'h0, 32'h0000_0A00, 1'b0, 32'h0000_FFFF, 32'h0000_0AFF}, // R4
    {2'd0, 3'd0, 32'h0000_0003, 32'h0, 1'b1, 32'h0000_FFFF, 32'h0000_0AFF}, // R10
    {2'd1, 3'd0, 32'h0000_000F, 32'h0, 1'b0, 32'h0000_FFF0, 32'h0000_0AF0}, // R6
    {2'd2, 3'd2, 32'h0, 32'h0000_5000, 1'b0, 32'h0000_FFF0, 32'h0000_5AF0}, // R4
    {2'd1, 3'd1, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0000_F0F0, 32'h0000_50F0}, // R6
    {2'd0, 3'd7, 32'h8000_0F00, 32'h0, 1'b1, 32'h8000_FFF0, 32'h0000_50F0}  // R7
  };

  task automatic check(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    claim_req = '0; rel_req = '0; wr_req = '0; wait_req = '0;
  endtask

  initial begin
    idle();
    claim_mask = '0; rel_mask = '0; wr_data = '0; wait_mask = '0; wait_target = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(own_map == 0 && bank_value == 0, "R1 map/bank", {own_map, bank_value}, 0);
    check(claim_ok == 0 && claim_grant == 0 && wait_stall == 0 && wait_done == 0,
          "R1 flags", {claim_ok, wait_stall, wait_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; int c; logic [31:0] m, d, em, eb; logic eo;
      {op, c, m, d, eo, em, eb} = {VEC[i][133:132], 29'd0, VEC[i][131:129], VEC[i][128:0]};
      case (op)
        2'd0: begin claim_req[c] = 1'b1; claim_mask[c*W +: W] = m; end
        2'd1: begin rel_req[c] = 1'b1; rel_mask[c*W +: W] = m; end
        default: begin wr_req[c] = 1'b1; wr_data[c*W +: W] = d; end
      endcase
      @(negedge clk);
      idle();
      check(claim_ok[c] == eo, $sformatf("R2 ok vec%0d", i), claim_ok[c], eo);
      check(claim_grant[c*W +: W] == (eo ? m : 32'h0), $sformatf("R2 grant vec%0d", i),
            claim_grant[c*W +: W], eo ? m : 32'h0);
      check(own_map == em, $sformatf("R7 map vec%0d", i), own_map, em);
      check(bank_value == eb, $sformatf("R4 bank vec%0d", i), bank_value, eb);
    end

    // R3: cores 3,4,5 claim together; 4 overlaps 3
    claim_req[3] = 1'b1; claim_mask[3*W +: W] = 32'h0003_0000;
    claim_req[4] = 1'b1; claim_mask[4*W +: W] = 32'h0002_0000;
    claim_req[5] = 1'b1; claim_mask[5*W +: W] = 32'h0004_0000;
    @(negedge clk);
    idle();
    check(claim_ok[5:3] == 3'b101, "R3 priority", claim_ok[5:3], 3'b101);
    check(claim_grant[4*W +: W] == 0, "R3 loser grant", claim_grant[4*W +: W], 0);
    check(own_map == 32'h8007_FFF0, "R3 map", own_map, 32'h8007_FFF0);
    @(negedge clk);
    check(claim_ok == 0, "R2 ok pulse", claim_ok, 0);

    // R8: core6 waits for bits 15:12 == A (currently 5)
    wait_req[6] = 1'b1; wait_mask[6*W +: W] = 32'h0000_F000; wait_target[6*W +: W] = 32'h1234_A000;
    @(negedge clk);
    idle();
    check(wait_stall[6] == 1'b1 && wait_done[6] == 1'b0, "R8 stalled", {wait_stall[6], wait_done[6]}, 2'b10);
    wr_req[2] = 1'b1; wr_data[2*W +: W] = 32'h0000_A000;
    @(negedge clk);
    idle();
    check(wait_done[6] == 1'b0, "R8 match cycle", wait_done[6], 0);
    @(negedge clk);
    check(wait_done[6] == 1'b1 && wait_stall[6] == 1'b0, "R8 done", {wait_stall[6], wait_done[6]}, 2'b01);
    @(negedge clk);
    check(wait_done[6] == 1'b0, "R8 one pulse", wait_done[6], 0);

    // R9: already matching
    wait_req[5] = 1'b1; wait_mask[5*W +: W] = 32'h0000_F0F0; wait_target[5*W +: W] = 32'h0000_A0F0;
    @(negedge clk);
    idle();
    check(wait_done[5] == 1'b0, "R9 early", wait_done[5], 0);
    @(negedge clk);
    check(wait_done[5] == 1'b1, "R9 done", wait_done[5], 1);
    @(negedge clk);
    check(wait_done[5] == 1'b0, "R9 pulse", wait_done[5], 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule